// File: doc/BRIEF.md
# Chained Address Register Loader

This block keeps the two operand address registers (first-operand and second-operand) and a one-character variant register of a character-serial processor. It updates them while an instruction is being extracted. A format code says which address portions the instruction carries. A per-opcode attribute says what an omitted second address means: either it is a copy of the first address, or the second register keeps its old value. A flag says whether a variant character came with the instruction. Any operand the instruction leaves out is supplied by the value the previous instruction left behind. Consecutive instructions can therefore be chained without restating their addresses.

A mode input selects the variant retention rule. In retain mode the variant survives any instruction that carries no variant character. In clobber mode, any instruction that has an address portion destroys the variant: it is forced to an invalid code and its valid flag drops. The datapath writes the register values it computes after execution through a separate write port. That port wins over an extraction in the same cycle. All outputs are registered.

Top module: `chain_addr_loader`

## Requirements
- R1: Reset is synchronous and active low. After reset, both address outputs are zero, the variant output is 0x3F and the variant-valid flag is 0.
- R2: In format 2'b00 (two addresses), an extract strobe loads `a_field` into the first register and `b_field` into the second register.
- R3: In format 2'b01 (first address only) with `dup_a`=1, an extract strobe loads `a_field` into both address registers.
- R4: In format 2'b01 with `dup_a`=0, an extract strobe loads `a_field` into the first register only, and the second register keeps its previous value.
- R5: In format 2'b10 (no addresses), an extract strobe leaves both address registers unchanged. Format code 2'b11 behaves the same as 2'b10.
- R6: When `var_present`=1, an extract strobe loads `var_field` into the variant register and sets the valid flag, in either mode and any format.
- R7: When `clobber_mode`=0 and `var_present`=0, an extract strobe leaves the variant register and its valid flag unchanged, in any format.
- R8: When `clobber_mode`=1 and `var_present`=0, an extract strobe in format 2'b00 or 2'b01 sets the variant to 0x3F and clears the valid flag. In format 2'b10 it leaves the variant unchanged.
- R9: When `wb_en`=1, the next clock edge loads `wb_a` into the first register and `wb_b` into the second register, even if `extract` is high in the same cycle. The variant register is still updated by that extraction.
- R10: With `extract`=0 and `wb_en`=0, all outputs hold their values.
- R11: Every register update is visible on the outputs in the cycle after the clock edge that samples the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| extract | input | 1 | Extraction strobe |
| fmt | input | 2 | Format: 00 two addresses, 01 first address only, 10/11 none |
| dup_a | input | 1 | An omitted second address is a copy of the first address (1) or keeps the old value (0) |
| var_present | input | 1 | A variant character accompanies the instruction |
| clobber_mode | input | 1 | An address portion destroys the variant |
| a_field | input | 16 | Extracted first address |
| b_field | input | 16 | Extracted second address |
| var_field | input | 6 | Extracted variant character |
| wb_en | input | 1 | Post-execution write request |
| wb_a | input | 16 | Post-execution first address |
| wb_b | input | 16 | Post-execution second address |
| a_reg | output | 16 | First-operand address register |
| b_reg | output | 16 | Second-operand address register |
| var_reg | output | 6 | Variant register |
| var_valid | output | 1 | Variant register holds a valid character |

## Verification
Each request is sampled by exactly one rising edge, and its result appears on the outputs immediately after that edge, with no further latency. The bench drives inputs on the falling edge and holds them across one rising edge. It compares the outputs at the next falling edge, half a period after the edge that produced them. Chained scenarios issue instructions back to back and carry an expected model of all three registers forward from one strobe to the next.

// File: rtl/chain_addr_pkg.sv
// Shared types and constants for the chained address register loader.
package chain_addr_pkg;
    typedef enum logic [1:0] {
        FMT_TWO  = 2'b00,
        FMT_ONE  = 2'b01,
        FMT_NONE = 2'b10,
        FMT_RSV  = 2'b11
    } fmt_e;
endpackage

// File: rtl/addr_pair_reg.sv
// Holds the two operand address registers.
// Assumes: the write port has priority over extraction; format 11 is treated as no-address.
module addr_pair_reg
    import chain_addr_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          extract,
    input  logic [1:0]    fmt,
    input  logic          dup_a,
    input  logic [AW-1:0] a_field,
    input  logic [AW-1:0] b_field,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_a,
    input  logic [AW-1:0] wb_b,
    output logic [AW-1:0] a_q,
    output logic [AW-1:0] b_q
);
    logic [AW-1:0] a_nx, b_nx;

    // Pick the next address values from format, attribute and write port.
    always_comb begin
        a_nx = a_q;
        b_nx = b_q;
        if (wb_en) begin
            a_nx = wb_a;
            b_nx = wb_b;
        end else if (extract) begin
            case (fmt_e'(fmt))
                FMT_TWO: begin
                    a_nx = a_field;
                    b_nx = b_field;
                end
                FMT_ONE: begin
                    a_nx = a_field;
                    if (dup_a) b_nx = a_field;
                end
                default: ;
            endcase
        end
    end

    // Register the address pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            a_q <= a_nx;
            b_q <= b_nx;
        end
    end

    AST_WB_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (a_q == $past(wb_a) && b_q == $past(wb_b))); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wb_en && !extract) |=> ($stable(a_q) && $stable(b_q))); // R10
    AST_DUP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wb_en && extract && fmt == 2'b01 && dup_a) |=> (b_q == a_q)); // R3
    AST_PRESERVE_B: assert property (@(posedge clk) disable iff (!rst_n)
        (!wb_en && extract && fmt == 2'b01 && !dup_a) |=> $stable(b_q)); // R4
    AST_NOADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wb_en && extract && fmt[1]) |=> ($stable(a_q) && $stable(b_q))); // R5
endmodule

// File: rtl/variant_reg.sv
// Holds the variant character and its valid flag.
// Assumes: a destroyed variant reads as INV_CODE with the valid flag cleared.
module variant_reg #(
    parameter int          VW       = 6,
    parameter logic [VW-1:0] INV_CODE = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          extract,
    input  logic [1:0]    fmt,
    input  logic          var_present,
    input  logic          clobber_mode,
    input  logic [VW-1:0] var_field,
    output logic [VW-1:0] v_q,
    output logic          v_ok
);
    logic has_addr;
    logic [VW-1:0] v_nx;
    logic          ok_nx;

    // An instruction has an address portion unless its format is no-address.
    assign has_addr = !fmt[1];

    // Decide whether to load, destroy or keep the variant.
    always_comb begin
        v_nx  = v_q;
        ok_nx = v_ok;
        if (extract) begin
            if (var_present) begin
                v_nx  = var_field;
                ok_nx = 1'b1;
            end else if (clobber_mode && has_addr) begin
                v_nx  = INV_CODE;
                ok_nx = 1'b0;
            end
        end
    end

    // Register the variant and its flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q  <= INV_CODE;
            v_ok <= 1'b0;
        end else begin
            v_q  <= v_nx;
            v_ok <= ok_nx;
        end
    end

    AST_VAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (extract && var_present) |=> (v_ok && v_q == $past(var_field))); // R6
    AST_VAR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (extract && !var_present && !clobber_mode) |=> ($stable(v_q) && $stable(v_ok))); // R7
    AST_VAR_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        (extract && !var_present && clobber_mode && !fmt[1]) |=> (!v_ok && v_q == INV_CODE)); // R8
    AST_VAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !extract |=> ($stable(v_q) && $stable(v_ok))); // R10
endmodule

// File: rtl/chain_addr_loader.sv
// Top level: address pair plus variant register updated on extraction.
// Assumes: single-cycle strobes; outputs are register outputs.
module chain_addr_loader #(
    parameter int AW = 16,
    parameter int VW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          extract,
    input  logic [1:0]    fmt,
    input  logic          dup_a,
    input  logic          var_present,
    input  logic          clobber_mode,
    input  logic [AW-1:0] a_field,
    input  logic [AW-1:0] b_field,
    input  logic [VW-1:0] var_field,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_a,
    input  logic [AW-1:0] wb_b,
    output logic [AW-1:0] a_reg,
    output logic [AW-1:0] b_reg,
    output logic [VW-1:0] var_reg,
    output logic          var_valid
);
    localparam logic [VW-1:0] INV_CODE = {VW{1'b1}};

    addr_pair_reg #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .extract(extract), .fmt(fmt), .dup_a(dup_a),
        .a_field(a_field), .b_field(b_field), .wb_en(wb_en), .wb_a(wb_a),
        .wb_b(wb_b), .a_q(a_reg), .b_q(b_reg)
    );

    variant_reg #(.VW(VW), .INV_CODE(INV_CODE)) u_var (
        .clk(clk), .rst_n(rst_n), .extract(extract), .fmt(fmt),
        .var_present(var_present), .clobber_mode(clobber_mode),
        .var_field(var_field), .v_q(var_reg), .v_ok(var_valid)
    );

    AST_INV_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !var_valid |-> (var_reg == INV_CODE)); // R8
endmodule

// File: tb/chain_addr_loader_test.sv
module chain_addr_loader_test;
    logic clk = 0, rst_n = 0;
    logic extract = 0, dup_a = 0, var_present = 0, clobber_mode = 0, wb_en = 0;
    logic [1:0] fmt = 0;
    logic [15:0] a_field = 0, b_field = 0, wb_a = 0, wb_b = 0;
    logic [5:0] var_field = 0;
    logic [15:0] a_reg, b_reg;
    logic [5:0] var_reg;
    logic var_valid;
    int n_chk = 0, n_bad = 0;
    logic [15:0] ea, eb;
    logic [5:0] ev;
    logic eok;

    always #10 clk = ~clk;

    chain_addr_loader uut (.*);

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic check(string req);
        n_chk++;
        if (a_reg !== ea || b_reg !== eb || var_reg !== ev || var_valid !== eok) begin
            n_bad++;
            $display("FAIL %s: got a=%h b=%h v=%h ok=%b exp a=%h b=%h v=%h ok=%b",
                     req, a_reg, b_reg, var_reg, var_valid, ea, eb, ev, eok);
        end
    endtask

    // Apply one cycle of stimulus and sample after the edge.
    task automatic step(input logic ex, input logic [1:0] f, input logic d,
                        input logic vp, input logic cm, input logic [15:0] a,
                        input logic [15:0] b, input logic [5:0] v);
        extract = ex; fmt = f; dup_a = d; var_present = vp; clobber_mode = cm;
        a_field = a; b_field = b; var_field = v;
        @(posedge clk); @(negedge clk);
        extract = 0; wb_en = 0;
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 0;
        @(posedge clk); @(negedge clk); rst_n = 1;
        ea = 0; eb = 0; ev = 6'h3F; eok = 0;
        check("R1");
    endtask

    task automatic t_two_addr;
        step(1, 2'b00, 0, 0, 0, 16'd900, 16'd700, 0);
        ea = 900; eb = 700; check("R2 R11");
        step(1, 2'b00, 1, 1, 0, 16'hBEEF, 16'h1234, 6'h15);
        ea = 16'hBEEF; eb = 16'h1234; ev = 6'h15; eok = 1; check("R2 R6");
    endtask

    task automatic t_one_addr;
        step(1, 2'b01, 1, 0, 0, 16'd49000, 16'hFFFF, 0);
        ea = 49000; eb = 49000; check("R3 R7");
        step(1, 2'b00, 0, 0, 0, 16'd10, 16'd20, 0);
        step(1, 2'b01, 0, 0, 0, 16'd30, 16'hAAAA, 0);
        ea = 30; eb = 20; check("R4");
    endtask

    task automatic t_no_addr;
        step(1, 2'b10, 1, 0, 0, 16'h5555, 16'h6666, 0);
        check("R5 fmt10");
        step(1, 2'b11, 1, 0, 1, 16'h7777, 16'h8888, 0);
        check("R5 R8 fmt11 keeps variant");
        step(1, 2'b10, 0, 1, 1, 16'h7777, 16'h8888, 6'h2A);
        ev = 6'h2A; eok = 1; check("R6 no-addr");
    endtask

    task automatic t_clobber;
        step(1, 2'b00, 0, 0, 0, 16'd1, 16'd2, 0);
        ea = 1; eb = 2; check("R7 retain two-addr");
        step(1, 2'b01, 0, 0, 1, 16'd3, 16'd4, 0);
        ea = 3; ev = 6'h3F; eok = 0; check("R8 one-addr kill");
        step(1, 2'b01, 1, 1, 1, 16'd5, 16'd6, 6'h07);
        ea = 5; eb = 5; ev = 6'h07; eok = 1; check("R6 clobber mode load");
        step(1, 2'b00, 0, 0, 1, 16'd8, 16'd9, 0);
        ea = 8; eb = 9; ev = 6'h3F; eok = 0; check("R8 two-addr kill");
    endtask

    task automatic t_writeback;
        step(1, 2'b00, 0, 1, 0, 16'd100, 16'd200, 6'h11);
        ea = 100; eb = 200; ev = 6'h11; eok = 1;
        wb_en = 1; wb_a = 16'd890; wb_b = 16'd690;
        step(1, 2'b00, 0, 1, 0, 16'd111, 16'd222, 6'h22);
        ea = 890; eb = 690; ev = 6'h22; check("R9 priority");
        step(0, 2'b00, 1, 1, 1, 16'hFFFF, 16'hFFFF, 6'h01);
        check("R10 idle");
        step(1, 2'b10, 0, 0, 0, 0, 0, 0);
        check("R5 R11 chain keeps writeback");
    endtask

    initial begin
        t_reset;
        t_two_addr;
        t_one_addr;
        t_no_addr;
        t_clobber;
        t_writeback;
        t_reset;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule